// File: doc/BRIEF.md
# Sticky Fault Status Byte with Host Interrupt

This block gathers fault events from a battery charger's supervision logic and shows them to a host as one 8-bit read-only status byte, together with an active-low interrupt pulse of fixed length. Watchdog expiry, boost-mode fault, battery overvoltage and a two-bit charge fault code are sticky. They stay in the byte until the host reads it. The three-bit thermistor field is never stored and always shows the live sensor code.

While any sticky fault is waiting for the host, further faults are added to the byte but raise no interrupt. Only a change in the thermistor code can still pulse the line. A read strobe returns the stored view and clears it on the same clock edge. A second read therefore shows the present condition. If a fault is still asserted when the byte clears, it is captured again at once. Two mask inputs stop charge faults and battery faults from raising the interrupt. They do not stop those faults from being stored.

Top module: `fault_latch_irq`

## Requirements
- R1: After reset, bits 7:3 of `fault_byte` are 0 and `irq_n` is 1. Bits 2:0 equal `ntc_state`.
- R2: Bit 7 is set by `ev_wdog`, bit 6 by `ev_boost` and bit 3 by `ev_batovp`. Each bit is set at the clock edge after its event and holds until a read.
- R3: Bits 5:4 hold the charge code: 00 means none, 01 input fault, 10 thermal shutdown, 11 safety timer. If several arrive together, thermal wins over input, and input wins over timer. A nonzero code is not overwritten before a read.
- R4: Bits 2:0 always equal the live `ntc_state` and are never stored. Codes: 000 normal, 001 sensor 1 cold, 010 sensor 1 hot, 011 sensor 2 cold, 100 sensor 2 hot, 101 both cold, 110 both hot.
- R5: A cycle with `rd_stb` high presents the stored byte. On that edge the sticky bits clear, so a following read returns only faults seen since then.
- R6: An event asserted on the clearing edge is stored again on that same edge. A fault still present when the byte clears therefore reappears.
- R7: One interrupt request drives `irq_n` low for exactly `PULSE_CYC` cycles, starting at the edge after the request.
- R8: While any sticky bit is set, new faults raise no interrupt.
- R9: Any change of `ntc_state` raises an interrupt, whether or not faults are stored.
- R10: With `mask_chg` at 0, charge faults raise no interrupt. With `mask_bat` at 0, `ev_batovp` raises no interrupt. Both kinds of fault are still stored. Watchdog and boost faults are never masked.
- R11: A request that arrives while a pulse is active is merged into that pulse. It neither extends the pulse nor starts a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_wdog | input | 1 | Watchdog expiry event |
| ev_boost | input | 1 | Boost-mode fault event |
| ev_input | input | 1 | Input supply fault event |
| ev_thermal | input | 1 | Thermal shutdown event |
| ev_timer | input | 1 | Safety timer expiry event |
| ev_batovp | input | 1 | Battery overvoltage event |
| ntc_state | input | 3 | Live thermistor code |
| mask_chg | input | 1 | 1 lets charge faults interrupt |
| mask_bat | input | 1 | 1 lets battery faults interrupt |
| rd_stb | input | 1 | Host reads the fault byte this cycle |
| fault_byte | output | 8 | Fault status byte |
| irq_n | output | 1 | Active-low interrupt pulse |

## Verification
A stale or missing sticky bit shows up in the byte at the first read, one cycle after the event edge. A wrongly computed pending flag shows up differently: either an interrupt appears while a fault is still unread, or the first fault after a clearing read is silent. Either is visible on `irq_n` one cycle after the event. A fault in the pulse counter changes the length of the low time, so it shows up within `PULSE_CYC` cycles. A fault in the merge logic shows up as a second pulse or a longer pulse whenever a thermistor change lands inside an active pulse.

// File: rtl/fault_latch_pkg.sv
package fault_latch_pkg;
  localparam int NTC_W  = 3;
  localparam int CODE_W = 2;
  localparam int BYTE_W = 8;

  localparam logic [CODE_W-1:0] CHG_NONE  = 2'b00;
  localparam logic [CODE_W-1:0] CHG_INPUT = 2'b01;
  localparam logic [CODE_W-1:0] CHG_THERM = 2'b10;
  localparam logic [CODE_W-1:0] CHG_TIMER = 2'b11;

  typedef struct packed {
    logic              wdog;
    logic              boost;
    logic [CODE_W-1:0] chg;
    logic              ovp;
  } flt_t;

  // thermal shutdown beats input fault, which beats timer expiry
  function automatic logic [CODE_W-1:0] chg_pick(input logic inp, input logic therm,
                                                 input logic tmr);
    if (therm)    return CHG_THERM;
    else if (inp) return CHG_INPUT;
    else if (tmr) return CHG_TIMER;
    else          return CHG_NONE;
  endfunction

  function automatic logic [BYTE_W-1:0] pack_byte(input flt_t f, input logic [NTC_W-1:0] ntc);
    return {f.wdog, f.boost, f.chg, f.ovp, ntc};
  endfunction
endpackage

// File: rtl/fault_capture.sv
module fault_capture
  import fault_latch_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ev_wdog,
  input  logic ev_boost,
  input  logic ev_input,
  input  logic ev_thermal,
  input  logic ev_timer,
  input  logic ev_batovp,
  input  logic mask_chg,
  input  logic mask_bat,
  input  logic rd_clr,
  output flt_t flt_q,
  output logic pending,
  output logic wake
);
  logic [CODE_W-1:0] new_code;
  flt_t              flt_d;

  assign new_code = chg_pick(ev_input, ev_thermal, ev_timer);

  always_comb begin
    if (rd_clr) begin
      flt_d.wdog  = ev_wdog;
      flt_d.boost = ev_boost;
      flt_d.ovp   = ev_batovp;
      flt_d.chg   = new_code;
    end else begin
      flt_d.wdog  = flt_q.wdog  | ev_wdog;
      flt_d.boost = flt_q.boost | ev_boost;
      flt_d.ovp   = flt_q.ovp   | ev_batovp;
      flt_d.chg   = (flt_q.chg != CHG_NONE) ? flt_q.chg : new_code;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flt_q <= '0;
    else        flt_q <= flt_d;
  end

  assign pending = (flt_q != '0);
  assign wake    = ev_wdog | ev_boost | (mask_chg & (new_code != CHG_NONE))
                 | (mask_bat & ev_batovp);
endmodule

// File: rtl/ntc_watch.sv
module ntc_watch
  import fault_latch_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NTC_W-1:0] ntc_state,
  output logic             ntc_chg
);
  logic [NTC_W-1:0] ntc_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ntc_prev <= '0;
    else        ntc_prev <= ntc_state;
  end

  assign ntc_chg = (ntc_state != ntc_prev);
endmodule

// File: rtl/irq_pulse.sv
module irq_pulse #(
  parameter int PULSE_CYC = 25600
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic irq_n
);
  localparam int CW = $clog2(PULSE_CYC + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (cnt != '0)         cnt <= cnt - CW'(1);
    else if (req)               cnt <= CW'(PULSE_CYC);
  end

  assign irq_n = (cnt == '0);
endmodule

// File: rtl/fault_latch_irq.sv
module fault_latch_irq
  import fault_latch_pkg::*;
#(
  parameter int PULSE_CYC = 25600
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_wdog,
  input  logic             ev_boost,
  input  logic             ev_input,
  input  logic             ev_thermal,
  input  logic             ev_timer,
  input  logic             ev_batovp,
  input  logic [NTC_W-1:0] ntc_state,
  input  logic             mask_chg,
  input  logic             mask_bat,
  input  logic             rd_stb,
  output logic [BYTE_W-1:0] fault_byte,
  output logic             irq_n
);
  flt_t flt_q;
  logic pending;
  logic wake;
  logic ntc_chg;
  logic irq_req;

  fault_capture u_cap (
    .clk(clk), .rst_n(rst_n),
    .ev_wdog(ev_wdog), .ev_boost(ev_boost), .ev_input(ev_input),
    .ev_thermal(ev_thermal), .ev_timer(ev_timer), .ev_batovp(ev_batovp),
    .mask_chg(mask_chg), .mask_bat(mask_bat), .rd_clr(rd_stb),
    .flt_q(flt_q), .pending(pending), .wake(wake)
  );

  ntc_watch u_ntc (
    .clk(clk), .rst_n(rst_n), .ntc_state(ntc_state), .ntc_chg(ntc_chg)
  );

  assign irq_req = (wake & ~pending) | ntc_chg;

  irq_pulse #(.PULSE_CYC(PULSE_CYC)) u_pulse (
    .clk(clk), .rst_n(rst_n), .req(irq_req), .irq_n(irq_n)
  );

  assign fault_byte = pack_byte(flt_q, ntc_state);
endmodule

// File: rtl/fault_latch_irq_chk.sv
module fault_latch_irq_chk #(
  parameter int PULSE_CYC = 25600
) (
  input logic       clk,
  input logic       rst_n,
  input logic       irq_n,
  input logic       irq_req,
  input logic       pending,
  input logic       rd_stb,
  input logic [4:0] sticky,
  input logic [2:0] ntc_state
);
  int low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      low_run <= 0;
    else if (!irq_n) low_run <= low_run + 1;
    else             low_run <= 0;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |-> (irq_n && sticky == 5'b0));

  // R7
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n) low_run <= PULSE_CYC);

  // R7
  pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(irq_n) |-> $past(irq_req));

  // R8
  quiet_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && $stable(ntc_state) && irq_n) |=> irq_n);

  // R9
  ntc_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(ntc_state) && irq_n) |=> !irq_n);

  // R2
  wdog_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky[4] && !rd_stb) |=> sticky[4]);

  // R3
  chg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky[2:1] != 2'b00 && !rd_stb) |=> $stable(sticky[2:1]));
endmodule

bind fault_latch_irq fault_latch_irq_chk #(.PULSE_CYC(PULSE_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .irq_req(irq_req), .pending(pending),
  .rd_stb(rd_stb), .sticky(fault_byte[7:3]), .ntc_state(ntc_state)
);

// File: tb/fault_latch_irq_bench.sv
`timescale 1ns/1ps
module fault_latch_irq_bench;
  localparam int PULSE = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_wdog = 0, ev_boost = 0, ev_input = 0, ev_thermal = 0, ev_timer = 0, ev_batovp = 0;
  logic [2:0] ntc_state = 3'b000;
  logic mask_chg = 1'b1, mask_bat = 1'b1;
  logic rd_stb = 1'b0;
  logic [7:0] fault_byte;
  logic irq_n;

  int total = 0;
  int bad = 0;
  logic [7:0] exp_q[$];

  // bench-side view of the sticky bits
  logic m_wd, m_bs, m_ov;
  logic [1:0] m_chg;

  always #2.5 clk = ~clk;

  fault_latch_irq #(.PULSE_CYC(PULSE)) u_fault_latch_irq (
    .clk(clk), .rst_n(rst_n), .ev_wdog(ev_wdog), .ev_boost(ev_boost),
    .ev_input(ev_input), .ev_thermal(ev_thermal), .ev_timer(ev_timer),
    .ev_batovp(ev_batovp), .ntc_state(ntc_state), .mask_chg(mask_chg),
    .mask_bat(mask_bat), .rd_stb(rd_stb), .fault_byte(fault_byte), .irq_n(irq_n)
  );

  function automatic logic [1:0] code_of(input logic th, input logic inp, input logic tm);
    casez ({th, inp, tm})
      3'b1??:  return 2'b10;
      3'b01?:  return 2'b01;
      3'b001:  return 2'b11;
      default: return 2'b00;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_wd <= 0; m_bs <= 0; m_ov <= 0; m_chg <= 2'b00;
    end else if (rd_stb) begin
      m_wd <= ev_wdog; m_bs <= ev_boost; m_ov <= ev_batovp;
      m_chg <= code_of(ev_thermal, ev_input, ev_timer);
    end else begin
      m_wd <= m_wd | ev_wdog; m_bs <= m_bs | ev_boost; m_ov <= m_ov | ev_batovp;
      if (m_chg == 2'b00) m_chg <= code_of(ev_thermal, ev_input, ev_timer);
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: compares the byte seen on every read cycle
  always @(negedge clk) begin
    #1;
    if (rd_stb) begin
      logic [7:0] e;
      e = (exp_q.size() > 0) ? exp_q.pop_front() : 8'hxx;
      chk("R5 read byte", int'(fault_byte), int'(e));
    end
  end

  task automatic do_read();
    exp_q.push_back({m_wd, m_bs, m_chg, m_ov, ntc_state});
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  task automatic fire(input logic wd, input logic bs, input logic inp,
                      input logic th, input logic tm, input logic ov);
    ev_wdog = wd; ev_boost = bs; ev_input = inp; ev_thermal = th; ev_timer = tm; ev_batovp = ov;
    @(negedge clk);
    ev_wdog = 0; ev_boost = 0; ev_input = 0; ev_thermal = 0; ev_timer = 0; ev_batovp = 0;
  endtask

  task automatic measure(output int n);
    n = 0;
    while (!irq_n && n < 100) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic wait_idle();
    while (!irq_n) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 byte", int'(fault_byte), 0);
    chk("R1 irq", int'(irq_n), 1);

    // R2 R7 watchdog, pulse length
    fire(1, 0, 0, 0, 0, 0);
    chk("R7 irq low", int'(irq_n), 0);
    measure(n);
    chk("R7 pulse len", n, PULSE);
    do_read();                       // 0x80
    do_read();                       // 0x00

    // R8 boost then ovp while pending
    fire(0, 1, 0, 0, 0, 0);
    chk("R2 boost irq", int'(irq_n), 0);
    wait_idle();
    fire(0, 0, 0, 0, 0, 1);
    chk("R8 no irq", int'(irq_n), 1);
    @(negedge clk);
    chk("R8 still quiet", int'(irq_n), 1);
    chk("R2 byte", int'(fault_byte), 8'h48);
    do_read(); do_read();

    // R3 priority and hold
    fire(0, 0, 1, 1, 1, 0);
    chk("R3 prio", int'(fault_byte[5:4]), 2);
    wait_idle();
    fire(0, 0, 0, 0, 1, 0);
    chk("R3 hold", int'(fault_byte[5:4]), 2);
    do_read(); do_read();
    fire(0, 0, 1, 0, 1, 0);
    chk("R3 input over timer", int'(fault_byte[5:4]), 1);
    wait_idle();
    do_read();
    fire(0, 0, 0, 0, 1, 0);
    chk("R3 timer code", int'(fault_byte[5:4]), 3);
    wait_idle();
    do_read();

    // R10 masks
    mask_chg = 0; mask_bat = 0;
    fire(0, 0, 1, 0, 0, 0);
    chk("R10 chg masked", int'(irq_n), 1);
    chk("R10 chg stored", int'(fault_byte), 8'h10);
    do_read();
    fire(0, 0, 0, 0, 0, 1);
    chk("R10 bat masked", int'(irq_n), 1);
    chk("R10 bat stored", int'(fault_byte), 8'h08);
    do_read();
    fire(1, 0, 0, 0, 0, 0);
    chk("R10 wdog unmasked", int'(irq_n), 0);
    wait_idle();
    do_read();
    mask_chg = 1; mask_bat = 1;

    // R9 R4 thermistor
    fire(1, 0, 0, 0, 0, 0);
    wait_idle();
    ntc_state = 3'b010;
    @(negedge clk);
    chk("R9 ntc irq", int'(irq_n), 0);
    chk("R4 live", int'(fault_byte[2:0]), 2);
    wait_idle();
    do_read();                       // 0x82
    do_read();                       // 0x02
    ntc_state = 3'b110;
    @(negedge clk);
    chk("R4 live both hot", int'(fault_byte), 8'h06);
    wait_idle();
    ntc_state = 3'b000;
    @(negedge clk);
    wait_idle();

    // R11 merge
    fire(1, 0, 0, 0, 0, 0);
    repeat (2) @(negedge clk);
    ntc_state = 3'b001;
    measure(n);
    chk("R11 merged", n, PULSE - 2);
    @(negedge clk);
    chk("R11 no extra", int'(irq_n), 1);
    do_read(); do_read();
    ntc_state = 3'b000;
    @(negedge clk);
    wait_idle();

    // R6 persistent fault
    ev_timer = 1;
    @(negedge clk);
    chk("R6 irq", int'(irq_n), 0);
    wait_idle();
    do_read();                       // 0x30
    chk("R6 relatched", int'(fault_byte), 8'h30);
    chk("R6 quiet", int'(irq_n), 1);
    do_read();                       // 0x30
    ev_timer = 0;
    do_read();                       // 0x30
    do_read();                       // 0x00

    // R5 read with event in the same cycle
    ev_boost = 1;
    do_read();                       // 0x00
    ev_boost = 0;
    chk("R5 new after clear", int'(fault_byte), 8'h40);
    chk("R5 irq after clear", int'(irq_n), 0);
    wait_idle();
    do_read();

    repeat (3) @(negedge clk);
    chk("R5 queue drained", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule